// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. Each request carries the address, a privilege mode (kernel or user) and an access kind (read, write or execute). The block first screens the address. An address that is not sign-extended fails at once. An address in the kernel direct-mapped window is translated without touching memory. Every other address is resolved by walking a three-level table in memory. The walk starts at the table root supplied on `ptbr` and needs at most three 64-bit reads.

The request side is a valid/ready stream. `req_ready` is high only while the walker is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the result has been delivered, so only one walk is ever in flight.

The memory side is also valid/ready. Once `mem_req_valid` rises, it stays high with `mem_req_addr` unchanged until the memory raises `mem_req_ready`. The walker then waits for one `mem_rsp_valid` beat carrying the entry on `mem_rsp_data`. A stalled `mem_req_ready` only delays the walk and never changes the result.

The result has no back-pressure. It is a one-cycle `resp_done` pulse that carries the physical address, the granted rights, the fault code, the original virtual address and the access-kind report.

Top module: `ptw_top`

## Requirements
- R1: If bits 63..43 of the virtual address are not all equal, the request ends with fault code 2 (access violation). No memory read is made, and `resp_done` is high in the cycle after acceptance.
- R2: A kernel request whose address has bit 63 set and bits 42..41 equal to binary 10 uses the direct window. It finishes with no memory read, and `resp_done` is high in the cycle after acceptance. The result is fault 0, `resp_pa` equal to VA[39:0] zero-extended, and `resp_prot` = 3'b111.
- R3: A user request that falls in the direct window of R2 ends with fault 2 and no memory read.
- R4: The walk reads the level-1 entry at ptbr + VA[42:33]*8, the level-2 entry at B1 + VA[32:23]*8 and the level-3 entry at B2 + VA[22:13]*8. Bn is bits 63..32 of the level-n entry shifted left by 13. On success, `resp_pa` equals bits 63..32 of the level-3 entry shifted left by 13, with VA[12:0] placed in the low bits.
- R5: An entry at any level with bit 0 clear stops the walk after that read with fault code 1 (translation not valid). No further read is issued.
- R6: A level-1 or level-2 entry with bit 8 clear stops the walk with fault 2. This applies in user mode as well.
- R7: The level-3 entry grants read and execute through bit 8 (kernel) or bit 9 (user), and write through bit 12 (kernel) or bit 13 (user). The access kind is encoded on `req_acc` as 0 read, 1 write and 2 execute. An access that the entry does not grant ends with fault 2.
- R8: Bits 1, 2 and 3 of the level-3 entry remove read, write and execute respectively. `resp_prot` reports the remaining rights as bit 0 read, bit 1 write and bit 2 execute. A granted access whose right was removed this way ends with fault 3 (read), 4 (write) or 5 (execute).
- R9: `resp_va` returns the request address. `resp_type` reports 0 for a read, 1 for a write and all ones for an execute.
- R10: `req_ready` stays low from acceptance until `resp_done`. `mem_req_valid` holds with a stable `mem_req_addr` until `mem_req_ready` is seen. `resp_done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 64 | Physical base of the level-1 table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 64 | Virtual address to translate |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Table entry |
| resp_done | output | 1 | One-cycle result pulse |
| resp_pa | output | 64 | Physical address |
| resp_prot | output | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| resp_fault | output | 3 | 0 none, 1 not valid, 2 access violation, 3/4/5 fault on read/write/execute |
| resp_va | output | 64 | Virtual address of the request |
| resp_type | output | 8 | Access report: 0 read, 1 write, all ones execute |

## Verification
Screened requests (R1–R3) must show `resp_done` in the first cycle after the accepting edge. When memory accepts immediately and answers one cycle later, a walk that makes N reads must show its pulse 2·N cycles after acceptance. Each directed task counts cycles from acceptance and counts the reads seen by the memory model. Both counts are compared with those figures, and the result fields are sampled only on the falling edge of the pulse cycle. In the stall scenario, `mem_req_ready` toggles, so only the result values and the read count are compared, not the timing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_TNV  = 3'd1,
    FLT_ACV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam int BIT_V   = 0;
  localparam int BIT_NR  = 1;
  localparam int BIT_NW  = 2;
  localparam int BIT_NX  = 3;
  localparam int BIT_KR  = 8;
  localparam int BIT_UR  = 9;
  localparam int BIT_KW  = 12;
  localparam int BIT_UW  = 13;
  localparam int FLAG_W  = 14;
endpackage

// File: rtl/ptw_va_check.sv
module ptw_va_check #(
  parameter int VA_W   = 64,
  parameter int IMPL_W = 43,
  parameter int WIN_W  = 40
) (
  input  logic [VA_W-1:0] va,
  input  logic            user,
  output logic            canon,
  output logic            win_hit,
  output ptw_pkg::fault_e win_fault,
  output logic [VA_W-1:0] win_pa
);
  import ptw_pkg::*;

  logic [VA_W-IMPL_W-1:0] upper;
  logic                   unused_va;

  assign upper     = va[VA_W-1:IMPL_W];
  assign canon     = (&upper) | ~(|upper);
  assign win_hit   = va[VA_W-1] && (va[IMPL_W-1:IMPL_W-2] == 2'b10);
  assign win_fault = user ? FLT_ACV : FLT_NONE;
  assign win_pa    = {{(VA_W-WIN_W){1'b0}}, va[WIN_W-1:0]};
  assign unused_va = ^va[IMPL_W-3:WIN_W];
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval (
  input  logic [ptw_pkg::FLAG_W-1:0] flags,
  input  logic                       user,
  input  logic [1:0]                 acc,
  output logic [2:0]                 prot,
  output ptw_pkg::fault_e            fault
);
  import ptw_pkg::*;

  logic       rd_ok, wr_ok;
  logic [2:0] base, need, masked;
  logic       unused_flags;

  assign rd_ok  = user ? flags[BIT_UR] : flags[BIT_KR];
  assign wr_ok  = user ? flags[BIT_UW] : flags[BIT_KW];
  assign base   = {rd_ok, wr_ok, rd_ok};
  assign masked = base & ~{flags[BIT_NX], flags[BIT_NW], flags[BIT_NR]};
  assign unused_flags = ^{flags[BIT_V], flags[7:4], flags[11:10]};

  always_comb begin
    case (acc)
      ACC_WR:  need = 3'b010;
      ACC_EX:  need = 3'b100;
      default: need = 3'b001;
    endcase
  end

  always_comb begin
    prot  = masked;
    fault = FLT_NONE;
    if ((base & need) == 3'b000) begin
      prot  = base;
      fault = FLT_ACV;
    end else if ((masked & need) == 3'b000) begin
      case (acc)
        ACC_WR:  fault = FLT_FOW;
        ACC_EX:  fault = FLT_FOE;
        default: fault = FLT_FOR;
      endcase
    end
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int VA_W    = 64,
  parameter int IMPL_W  = 43,
  parameter int PG_BITS = 13,
  parameter int IDX_W   = 10,
  parameter int LEVELS  = 3,
  parameter int WIN_W   = 40,
  parameter int TYPE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   ptbr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_user,
  input  logic [1:0]        req_acc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data,
  output logic              resp_done,
  output logic [VA_W-1:0]   resp_pa,
  output logic [2:0]        resp_prot,
  output logic [2:0]        resp_fault,
  output logic [VA_W-1:0]   resp_va,
  output logic [TYPE_W-1:0] resp_type
);
  import ptw_pkg::*;

  localparam int PFN_W    = VA_W / 2;
  localparam int ENTRY_SH = $clog2(VA_W / 8);
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int PAD_W    = VA_W - PFN_W - PG_BITS;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_st_e        st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0] va_q, addr_q, pa_q;
  logic            user_q;
  logic [1:0]      acc_q;
  logic [2:0]      prot_q;
  fault_e          fault_q;

  logic            canon, win_hit;
  fault_e          win_fault;
  logic [VA_W-1:0] win_pa;
  logic [2:0]      leaf_prot;
  fault_e          leaf_fault;

  logic [IDX_W-1:0] idx_a [LEVELS];
  logic [IDX_W-1:0] first_idx, next_idx;
  logic [LVL_W-1:0] nxt_lvl;
  logic [VA_W-1:0]  next_base, leaf_pa;
  logic             fire;
  logic             unused_rsp;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_a[g] = va_q[PG_BITS + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign first_idx = req_va[PG_BITS + IDX_W*(LEVELS-1) +: IDX_W];
  assign nxt_lvl   = lvl_q + 1'b1;
  assign next_idx  = idx_a[nxt_lvl];
  assign next_base = {{PAD_W{1'b0}}, mem_rsp_data[VA_W-1:PFN_W], {PG_BITS{1'b0}}};
  assign leaf_pa   = {{PAD_W{1'b0}}, mem_rsp_data[VA_W-1:PFN_W], va_q[PG_BITS-1:0]};
  assign fire      = req_valid && req_ready;
  assign unused_rsp = ^mem_rsp_data[PFN_W-1:FLAG_W];

  ptw_va_check #(.VA_W(VA_W), .IMPL_W(IMPL_W), .WIN_W(WIN_W)) u_vachk (
    .va(req_va), .user(req_user), .canon(canon), .win_hit(win_hit),
    .win_fault(win_fault), .win_pa(win_pa)
  );

  ptw_leaf_eval u_leaf (
    .flags(mem_rsp_data[FLAG_W-1:0]), .user(user_q), .acc(acc_q),
    .prot(leaf_prot), .fault(leaf_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      user_q  <= 1'b0;
      acc_q   <= ACC_RD;
      prot_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (fire) begin
          va_q    <= req_va;
          user_q  <= req_user;
          acc_q   <= req_acc;
          lvl_q   <= '0;
          pa_q    <= '0;
          prot_q  <= '0;
          fault_q <= FLT_NONE;
          if (!canon) begin
            fault_q <= FLT_ACV;
            st_q    <= ST_DONE;
          end else if (win_hit) begin
            fault_q <= win_fault;
            if (win_fault == FLT_NONE) begin
              pa_q   <= win_pa;
              prot_q <= 3'b111;
            end
            st_q <= ST_DONE;
          end else begin
            addr_q <= ptbr + (VA_W'(first_idx) << ENTRY_SH);
            st_q   <= ST_RD;
          end
        end
        ST_RD: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[BIT_V]) begin
            fault_q <= FLT_TNV;
            st_q    <= ST_DONE;
          end else if (lvl_q != LAST_LVL) begin
            if (!mem_rsp_data[BIT_KR]) begin
              fault_q <= FLT_ACV;
              st_q    <= ST_DONE;
            end else begin
              addr_q <= next_base + (VA_W'(next_idx) << ENTRY_SH);
              lvl_q  <= nxt_lvl;
              st_q   <= ST_RD;
            end
          end else begin
            pa_q    <= leaf_pa;
            prot_q  <= leaf_prot;
            fault_q <= leaf_fault;
            st_q    <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_RD);
  assign mem_req_addr  = addr_q;
  assign resp_done     = (st_q == ST_DONE);
  assign resp_pa       = pa_q;
  assign resp_prot     = prot_q;
  assign resp_fault    = fault_q;
  assign resp_va       = va_q;
  assign resp_type     = (acc_q == ACC_EX) ? {TYPE_W{1'b1}} : TYPE_W'(acc_q);
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk #(
  parameter int VA_W   = 64,
  parameter int IMPL_W = 43,
  parameter int WIN_W  = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            req_user,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            resp_done,
  input logic [VA_W-1:0] resp_pa,
  input logic [2:0]      resp_prot,
  input logic [2:0]      resp_fault
);
  logic            take, c_canon, c_win;
  logic [VA_W-1:0] c_wpa;

  assign take    = req_valid && req_ready;
  assign c_canon = (req_va[VA_W-1:IMPL_W] == '0) || (req_va[VA_W-1:IMPL_W] == '1);
  assign c_win   = req_va[VA_W-1] && req_va[IMPL_W-1] && !req_va[IMPL_W-2];
  assign c_wpa   = {{(VA_W-WIN_W){1'b0}}, req_va[WIN_W-1:0]};

  assert_bad_va_acv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !c_canon) |=> (resp_done && resp_fault == 3'd2 && !mem_req_valid));

  assert_kwin_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && c_canon && c_win && !req_user) |=>
      (resp_done && resp_fault == 3'd0 && resp_prot == 3'b111 && resp_pa == $past(c_wpa)));

  assert_uwin_acv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && c_canon && c_win && req_user) |=> (resp_done && resp_fault == 3'd2));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_busy_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || resp_done) |-> !req_ready);

  assert_ok_has_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_fault == 3'd0) |-> (resp_prot != 3'b000));
endmodule

bind ptw_top ptw_top_chk #(.VA_W(VA_W), .IMPL_W(IMPL_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_user(req_user), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .resp_done(resp_done), .resp_pa(resp_pa), .resp_prot(resp_prot),
  .resp_fault(resp_fault)
);

// File: tb/sim_ptw_top.sv
`timescale 1ns/1ps
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ptbr = 64'h1_0000;
  logic        req_valid = 1'b0, req_ready, req_user = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req_valid, mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [63:0] mem_req_addr, mem_rsp_data = '0;
  logic        resp_done;
  logic [63:0] resp_pa, resp_va;
  logic [2:0]  resp_prot, resp_fault;
  logic [7:0]  resp_type;

  int n_chk = 0, n_bad = 0, n_reads = 0;
  logic stall = 1'b0;
  logic [63:0] ma [3];
  logic [63:0] md [3];
  int lat;
  logic busy_bad;
  logic [63:0] g_pa, g_va;
  logic [2:0]  g_prot, g_flt;
  logic [7:0]  g_type;

  always #4 clk = ~clk;

  ptw_top u0 (.*);

  function automatic logic [63:0] lookup(input logic [63:0] a);
    lookup = '0;
    for (int i = 0; i < 3; i++) if (ma[i] == a) lookup = md[i];
  endfunction

  always @(posedge clk) begin
    if (stall) mem_req_ready <= ~mem_req_ready;
    else       mem_req_ready <= 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= lookup(mem_req_addr);
      n_reads       <= n_reads + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [31:0] frame, input logic [15:0] fl);
    pte = {frame, 16'h0, fl};
  endfunction

  task automatic set_walk(input logic [63:0] va, input logic [63:0] p1,
                          input logic [63:0] p2, input logic [63:0] p3);
    ma[0] = ptbr + {51'd0, va[42:33], 3'd0};
    md[0] = p1;
    ma[1] = {19'd0, p1[63:32], 13'd0} + {51'd0, va[32:23], 3'd0};
    md[1] = p2;
    ma[2] = {19'd0, p2[63:32], 13'd0} + {51'd0, va[22:13], 3'd0};
    md[2] = p3;
  endtask

  task automatic run(input logic [63:0] va, input logic user, input logic [1:0] acc);
    @(negedge clk);
    n_reads  = 0;
    busy_bad = 1'b0;
    req_va = va; req_user = user; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_done && lat < 200) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    g_pa = resp_pa; g_va = resp_va; g_prot = resp_prot; g_flt = resp_fault; g_type = resp_type;
    chk("R10 result pulse arrived", {63'd0, resp_done}, 64'd1);
    chk("R10 busy until done", {63'd0, busy_bad}, 64'd0);
    @(negedge clk);
    chk("R10 pulse one cycle", {63'd0, resp_done}, 64'd0);
  endtask

  localparam logic [63:0] VA_W1 = (64'd3 << 33) | (64'd5 << 23) | (64'd7 << 13) | 64'h123;
  localparam logic [63:0] PA_W1 = (64'hABCDE << 13) | 64'h123;

  task automatic t_reset();
    chk("R10 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R10 reset done low", {63'd0, resp_done}, 64'd0);
    chk("R10 reset no read", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_noncanon();
    run(64'h0000_0800_0000_0000, 1'b0, 2'd0);
    chk("R1 fault acv", {61'd0, g_flt}, 64'd2);
    chk("R1 no read", n_reads, 0);
    chk("R1 latency", lat, 0);
    run(64'hFF7F_FFFF_FFFF_0000, 1'b0, 2'd0);
    chk("R1 negative noncanon", {61'd0, g_flt}, 64'd2);
  endtask

  task automatic t_kwin();
    run(64'hFFFF_FD12_3456_7898, 1'b0, 2'd1);
    chk("R2 fault none", {61'd0, g_flt}, 64'd0);
    chk("R2 pa", g_pa, 64'h12_3456_7898);
    chk("R2 prot rwx", {61'd0, g_prot}, 64'd7);
    chk("R2 no read", n_reads, 0);
    chk("R2 latency", lat, 0);
    chk("R9 write type", {56'd0, g_type}, 64'd1);
  endtask

  task automatic t_uwin();
    run(64'hFFFF_FD12_3456_7898, 1'b1, 2'd0);
    chk("R3 fault acv", {61'd0, g_flt}, 64'd2);
    chk("R3 no read", n_reads, 0);
  endtask

  task automatic t_walk_ok();
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h1101));
    run(VA_W1, 1'b0, 2'd0);
    chk("R4 pa", g_pa, PA_W1);
    chk("R4 fault none", {61'd0, g_flt}, 64'd0);
    chk("R7 kernel rwx", {61'd0, g_prot}, 64'd7);
    chk("R4 three reads", n_reads, 3);
    chk("R4 latency", lat, 6);
    chk("R9 va echo", g_va, VA_W1);
    chk("R9 read type", {56'd0, g_type}, 64'd0);
  endtask

  task automatic t_neg_walk();
    logic [63:0] va;
    va = 64'hFFFF_FFFF_FFFF_E456;
    set_walk(va, pte(32'h20, 16'h0101), pte(32'h28, 16'h0101), pte(32'h77, 16'h0101));
    run(va, 1'b0, 2'd2);
    chk("R4 negative va pa", g_pa, (64'h77 << 13) | 64'h456);
    chk("R8 exec ok", {61'd0, g_flt}, 64'd0);
    chk("R9 exec type", {56'd0, g_type}, 64'hFF);
  endtask

  task automatic t_user_perm();
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h2001));
    run(VA_W1, 1'b1, 2'd1);
    chk("R7 user write ok", {61'd0, g_flt}, 64'd0);
    chk("R7 user write prot", {61'd0, g_prot}, 64'd2);
    run(VA_W1, 1'b1, 2'd0);
    chk("R7 user read acv", {61'd0, g_flt}, 64'd2);
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h0101));
    run(VA_W1, 1'b0, 2'd1);
    chk("R7 kernel write acv", {61'd0, g_flt}, 64'd2);
  endtask

  task automatic t_fault_on();
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h1105));
    run(VA_W1, 1'b0, 2'd1);
    chk("R8 fow code", {61'd0, g_flt}, 64'd4);
    chk("R8 fow prot", {61'd0, g_prot}, 64'd5);
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h0109));
    run(VA_W1, 1'b0, 2'd2);
    chk("R8 foe code", {61'd0, g_flt}, 64'd5);
    chk("R9 foe type", {56'd0, g_type}, 64'hFF);
    chk("R9 foe va", g_va, VA_W1);
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h0103));
    run(VA_W1, 1'b0, 2'd0);
    chk("R8 for code", {61'd0, g_flt}, 64'd3);
    chk("R8 for prot", {61'd0, g_prot}, 64'd4);
  endtask

  task automatic t_invalid();
    set_walk(VA_W1, pte(32'h10, 16'h0100), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h1101));
    run(VA_W1, 1'b0, 2'd0);
    chk("R5 l1 tnv", {61'd0, g_flt}, 64'd1);
    chk("R5 l1 reads", n_reads, 1);
    chk("R5 l1 latency", lat, 2);
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0000), pte(32'hABCDE, 16'h1101));
    run(VA_W1, 1'b0, 2'd0);
    chk("R5 l2 tnv", {61'd0, g_flt}, 64'd1);
    chk("R5 l2 reads", n_reads, 2);
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h1100));
    run(VA_W1, 1'b0, 2'd0);
    chk("R5 l3 tnv", {61'd0, g_flt}, 64'd1);
    chk("R5 l3 reads", n_reads, 3);
  endtask

  task automatic t_mid_kre();
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0201), pte(32'hABCDE, 16'h3301));
    run(VA_W1, 1'b1, 2'd0);
    chk("R6 l2 acv user", {61'd0, g_flt}, 64'd2);
    chk("R6 l2 reads", n_reads, 2);
    set_walk(VA_W1, pte(32'h10, 16'h0001), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h1101));
    run(VA_W1, 1'b0, 2'd0);
    chk("R6 l1 acv", {61'd0, g_flt}, 64'd2);
    chk("R6 l1 reads", n_reads, 1);
  endtask

  task automatic t_stall();
    set_walk(VA_W1, pte(32'h10, 16'h0101), pte(32'h18, 16'h0101), pte(32'hABCDE, 16'h1101));
    stall = 1'b1;
    run(VA_W1, 1'b0, 2'd0);
    stall = 1'b0;
    chk("R10 stall pa", g_pa, PA_W1);
    chk("R10 stall fault", {61'd0, g_flt}, 64'd0);
    chk("R10 stall reads", n_reads, 3);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin ma[i] = '1; md[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noncanon();
    t_kwin();
    t_uwin();
    t_walk_ok();
    t_neg_walk();
    t_user_perm();
    t_fault_on();
    t_invalid();
    t_mid_kre();
    t_stall();
    finish_run();
  end
endmodule